// File: doc/BRIEF.md
# HD Line Number Checker

This block checks the line number embedded in the luma channel of a high-definition video word stream. An internal expected count comes from the receiver's own line and frame timing, not from the received data. After each end-of-active-video marker, the block captures the two line-number words that follow. It then compares the line number they carry with the expected count. A mismatch raises a sticky error flag. So does a line whose line-number words are missing or malformed. The flag stays set until the host clears it.

The surrounding receiver supplies four things:

- the luma words with a word strobe;
- a marker on the last word of each end-of-active-video sequence;
- a frame-start indication from its flywheel, coincident with that marker on the first line of a frame;
- a mode select that enables checking only for HD streams.

The frame length in lines is programmable.

Top module: `hd_ln_checker`

## Requirements
- R1: After reset the error flag `ln_err_o` is low.
- R2: Line-number word format. The first valid word after the marker carries LN[6:0] in bits [8:2]. The second carries LN[10:7] in bits [5:2]. A word is well formed only if bit 9 equals the inverse of bit 8 and bits [1:0] are zero. The second word also needs bits [8:6] to be zero. Cycles with `word_valid_i` low are skipped.
- R3: When the received line number equals the expected count, the flag stays low.
- R4: When the received line number differs from the expected count in any bit, the flag goes high.
- R5: The flag goes high when a line's number is missing. That covers a malformed line-number word, and a new marker arriving before both line-number words have been taken.
- R6: A marker with `frame_start_i` high sets the expected count to 1. Every other marker advances the count by one.
- R7: A marker without frame start, seen while the expected count is at or above `lines_per_frame_i`, wraps the count to 1.
- R8: Once set, the flag holds until a cycle with `err_clear_i` high, which clears it.
- R9: With `hd_mode_i` low, no error is raised, and any partly captured line number is discarded.
- R10: No error is raised before the first frame start has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hd_mode_i | input | 1 | High enables checking (HD stream) |
| word_valid_i | input | 1 | Strobe for the luma word |
| luma_i | input | 10 | Luma channel word |
| eav_i | input | 1 | Marks the last word of an end-of-active-video sequence (qualified by strobe) |
| frame_start_i | input | 1 | Flywheel frame start, given together with `eav_i` on the first line |
| lines_per_frame_i | input | 11 | Number of lines in a frame |
| err_clear_i | input | 1 | Host clear of the error flag |
| ln_err_o | output | 1 | Sticky line-number error flag |

## Verification
The hardest situations to reach are those where the upper line-number bits matter. One is a count that wraps at a realistic frame length. The other is a mismatch confined to LN[10:7]. Reaching either needs the expected count to walk past 127 and up to the frame length. The bench therefore drives a full 1125-line frame of correct line numbers, then checks the wrap to line 1. It then sends a line whose only wrong bit lies in the second line-number word. Missing line numbers are provoked in two ways: a malformed first word, and two back-to-back markers.

// File: rtl/hd_ln_pkg.sv
package hd_ln_pkg;
  localparam int unsigned WORD_W = 10;
  localparam int unsigned LN_W   = 11;
  localparam int unsigned LO_W   = 7;
  localparam int unsigned HI_W   = LN_W - LO_W;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_LO   = 2'd1,
    CAP_HI   = 2'd2
  } cap_state_e;

  function automatic logic lo_word_ok(input logic [WORD_W-1:0] w);
    return (w[9] == ~w[8]) && (w[1:0] == 2'b00);
  endfunction

  function automatic logic hi_word_ok(input logic [WORD_W-1:0] w);
    return (w[9] == ~w[8]) && (w[8:6] == 3'b000) && (w[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/hd_ln_expect.sv
module hd_ln_expect
  import hd_ln_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_end_i,
  input  logic            frame_start_i,
  input  logic [LN_W-1:0] lines_per_frame_i,
  output logic [LN_W-1:0] exp_o,
  output logic            synced_o
);
  logic [LN_W-1:0] exp_q;
  logic            synced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q    <= '0;
      synced_q <= 1'b0;
    end else if (line_end_i) begin
      if (frame_start_i) begin
        exp_q    <= LN_W'(1);
        synced_q <= 1'b1;
      end else if (synced_q) begin
        exp_q <= (exp_q >= lines_per_frame_i) ? LN_W'(1) : exp_q + LN_W'(1);
      end
    end
  end

  assign exp_o    = exp_q;
  assign synced_o = synced_q;

  assert_fs_loads_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_end_i && frame_start_i) |=> (exp_o == LN_W'(1) && synced_o));

  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_end_i && !frame_start_i && synced_o && exp_o >= lines_per_frame_i)
      |=> (exp_o == LN_W'(1)));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_i |=> $stable(exp_o));
endmodule

// File: rtl/hd_ln_capture.sv
module hd_ln_capture
  import hd_ln_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              word_valid_i,
  input  logic              eav_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ln_vld_o,
  output logic [LN_W-1:0]   ln_o,
  output logic              miss_o
);
  cap_state_e      state_q, state_d;
  logic [LO_W-1:0] lo_q, lo_d;
  logic [LN_W-1:0] ln_q, ln_d;
  logic            vld_q, vld_d, miss_q, miss_d;

  always_comb begin
    state_d = state_q;
    lo_d    = lo_q;
    ln_d    = ln_q;
    vld_d   = 1'b0;
    miss_d  = 1'b0;
    if (!enable_i) begin
      state_d = CAP_IDLE;
    end else if (word_valid_i) begin
      unique case (state_q)
        CAP_IDLE: if (eav_i) state_d = CAP_LO;
        CAP_LO: begin
          if (eav_i) begin
            miss_d = 1'b1;
          end else if (lo_word_ok(word_i)) begin
            lo_d    = word_i[8:2];
            state_d = CAP_HI;
          end else begin
            miss_d  = 1'b1;
            state_d = CAP_IDLE;
          end
        end
        CAP_HI: begin
          if (eav_i) begin
            miss_d  = 1'b1;
            state_d = CAP_LO;
          end else if (hi_word_ok(word_i)) begin
            vld_d   = 1'b1;
            ln_d    = {word_i[HI_W+1:2], lo_q};
            state_d = CAP_IDLE;
          end else begin
            miss_d  = 1'b1;
            state_d = CAP_IDLE;
          end
        end
        default: state_d = CAP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CAP_IDLE;
      lo_q    <= '0;
      ln_q    <= '0;
      vld_q   <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lo_q    <= lo_d;
      ln_q    <= ln_d;
      vld_q   <= vld_d;
      miss_q  <= miss_d;
    end
  end

  assign ln_vld_o = vld_q;
  assign ln_o     = ln_q;
  assign miss_o   = miss_q;

  assert_vld_miss_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ln_vld_o && miss_o));

  assert_disabled_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!ln_vld_o && !miss_o));

  assert_eav_restarts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && word_valid_i && eav_i && state_q != CAP_IDLE) |=> miss_o);
endmodule

// File: rtl/hd_ln_checker.sv
module hd_ln_checker
  import hd_ln_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hd_mode_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] luma_i,
  input  logic              eav_i,
  input  logic              frame_start_i,
  input  logic [LN_W-1:0]   lines_per_frame_i,
  input  logic              err_clear_i,
  output logic              ln_err_o
);
  logic [LN_W-1:0] exp_ln, rx_ln;
  logic            synced, rx_vld, rx_miss, err_set, err_q;

  hd_ln_expect i_expect (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .line_end_i        (word_valid_i & eav_i),
    .frame_start_i     (frame_start_i),
    .lines_per_frame_i (lines_per_frame_i),
    .exp_o             (exp_ln),
    .synced_o          (synced)
  );

  hd_ln_capture i_capture (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (hd_mode_i),
    .word_valid_i (word_valid_i),
    .eav_i        (eav_i),
    .word_i       (luma_i),
    .ln_vld_o     (rx_vld),
    .ln_o         (rx_ln),
    .miss_o       (rx_miss)
  );

  assign err_set = hd_mode_i & synced & (rx_miss | (rx_vld & (rx_ln != exp_ln)));

  // a new error in the clear cycle is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_set | (err_q & ~err_clear_i);
  end

  assign ln_err_o = err_q;

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ln_err_o && !err_clear_i) |=> ln_err_o);

  assert_sd_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hd_mode_i && !ln_err_o) |=> !ln_err_o);

  assert_unsynced_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!synced && !ln_err_o) |=> !ln_err_o);

  assert_match_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ln_err_o && !rx_miss && (!rx_vld || rx_ln == exp_ln)) |=> !ln_err_o);
endmodule

// File: tb/test_hd_ln_checker.sv
module test_hd_ln_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hd_mode = 1'b1;
  logic        wvalid = 1'b0;
  logic [9:0]  luma = '0;
  logic        eav = 1'b0;
  logic        fs = 1'b0;
  logic [10:0] lpf = 11'd5;
  logic        clr = 1'b0;
  logic        ln_err;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hd_ln_checker i_hd_ln_checker (
    .clk_i(clk), .rst_ni(rst_n), .hd_mode_i(hd_mode), .word_valid_i(wvalid),
    .luma_i(luma), .eav_i(eav), .frame_start_i(fs), .lines_per_frame_i(lpf),
    .err_clear_i(clr), .ln_err_o(ln_err));

  task automatic check(input logic exp, input string req);
    checks++;
    if (ln_err !== exp) begin
      errors++;
      $display("FAIL %s: ln_err_o=%b expected %b", req, ln_err, exp);
    end
  endtask

  task automatic put(input logic [9:0] w, input logic e, input logic f);
    @(negedge clk);
    wvalid = 1'b1; luma = w; eav = e; fs = f;
    @(negedge clk);
    wvalid = 1'b0; eav = 1'b0; fs = 1'b0;
  endtask

  // mode 0 normal, 1 malformed first word, 2 two markers, 3 gaps
  task automatic send_line(input int ln, input bit f, input int mode);
    logic [10:0] v;
    logic [9:0]  lo, hi;
    v  = 11'(ln);
    lo = {~v[6], v[6:0], 2'b00};
    hi = {1'b1, 3'b000, v[10:7], 2'b00};
    if (mode == 2) begin
      put(10'h274, 1'b1, 1'b0);
      put(10'h274, 1'b1, f);
    end else begin
      put(10'h274, 1'b1, f);
    end
    if (mode == 3) repeat (3) @(negedge clk);
    put((mode == 1) ? {v[6], v[6:0], 2'b00} : lo, 1'b0, 1'b0);
    if (mode == 3) repeat (2) @(negedge clk);
    put(hi, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check(1'b0, "R8 clear");
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(1'b0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 after release");
  endtask

  task automatic t_unsynced();
    send_line(9, 0, 0);
    check(1'b0, "R10 before frame start");
  endtask

  task automatic t_count_and_wrap();
    for (int l = 1; l <= 5; l++) send_line(l, l == 1, 0);
    check(1'b0, "R3 R6 lines 1-5 match");
    send_line(1, 0, 0);
    check(1'b0, "R7 wrap to 1");
  endtask

  task automatic t_mismatch();
    send_line(5, 0, 0);              // expected 2
    check(1'b1, "R4 mismatch");
    repeat (10) @(negedge clk);
    check(1'b1, "R8 sticky");
    clear_flag();
  endtask

  task automatic t_missing();
    send_line(3, 0, 1);              // expected 3, malformed word
    check(1'b1, "R5 malformed word");
    clear_flag();
    send_line(1, 1, 2);              // second marker is frame start, ln 1 ok
    check(1'b1, "R5 marker before words");
    clear_flag();
  endtask

  task automatic t_sd_mode();
    @(negedge clk); hd_mode = 1'b0;
    send_line(9, 0, 0);              // count advances to 2
    check(1'b0, "R9 SD mode ignored");
    @(negedge clk); hd_mode = 1'b1;
    send_line(3, 0, 0);
    check(1'b0, "R9 HD resumes");
  endtask

  task automatic t_gaps();
    send_line(4, 0, 3);
    check(1'b0, "R2 strobe gaps");
  endtask

  task automatic t_long_frame();
    @(negedge clk); lpf = 11'd1125;
    for (int l = 1; l <= 1125; l++) send_line(l, l == 1, 0);
    check(1'b0, "R2 R3 full 1125-line frame");
    send_line(1, 0, 0);
    check(1'b0, "R7 wrap at 1125");
    send_line(2 + 128, 0, 0);        // only LN[7] wrong
    check(1'b1, "R2 R4 upper bits mismatch");
    clear_flag();
  endtask

  initial begin
    t_reset();
    t_unsynced();
    t_count_and_wrap();
    t_mismatch();
    t_missing();
    t_sd_mode();
    t_gaps();
    t_long_frame();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule